// File: doc/BRIEF.md
# Serial LED Shift-Out Engine

This block drives a chain of external serial-in, parallel-out shift registers that hold 17 output bits, for example LED drivers. It produces three pins: a shift clock, a serial data line and a latch strobe. The bits come from one of two sources. Software can write a data word through a small word-addressed register port, or, in PWM mode, the engine samples 17 channel levels from external waveform generators and sends them out on its own.

A sequence first sends the 17 bits, most significant first, one bit per shift-clock period. It then pulses the latch for one shift-clock period. While a sequence runs, a busy flag reads as 1. While busy is set, writes to the data word are refused, and so is any attempt to switch into PWM mode. Software polls the flag before it writes. The shift clock is the system clock divided by 4, 8, 16 or 32. A programmable delay sets how far the shift clock's rising edge lags the moment the data changes.

In PWM mode an all-zero channel pattern never starts a shift. A pattern that equals the one last sent does not start one either. Because of this, software must clear the chain with an explicit all-zero data write before it enables PWM mode.

Top module: `serial_led_out`

## Requirements
- R1: After reset, busy is 0, all three chain pins are low, and all four registers read 0. The registers are at word addresses 0 (data/status), 1 (divider), 2 (delay) and 3 (mode).
- R2: A write to address 0 is accepted when the engine is idle and not in PWM mode. From the next cycle, bit 31 of address 0 reads 1, and bits [16:0] read the written word.
- R3: A sequence sends exactly 17 bits, most significant first. Each bit is sampled on a rising edge of the shift clock. A latch pulse follows, one slot long, and then busy clears. Busy stays high for 18 slots in total.
- R4: Divider code c (address 1, bits [1:0]) gives a slot length of 4<<c system cycles. Within each slot the shift clock is high for half a slot.
- R5: The shift clock rises d+1 system cycles after the slot starts, where d is the delay (address 2, bits [3:0]). The value of d is limited to half the slot length minus one.
- R6: A data write made while busy is dropped. The readback value and the shifted bits are unchanged, and no extra sequence starts.
- R7: Mode bit 0 (address 3) selects a device without a storage latch. No latch pulse is sent, and busy lasts 17 slots.
- R8: Setting mode bit 1 (PWM mode) while busy is refused, and bit 1 reads back 0. When the engine is idle, the same write is accepted.
- R9: In PWM mode, a sequence starts from the sampled channel pattern whenever that pattern is non-zero and differs from the pattern last sent. A pattern that stays the same starts no further sequence.
- R10: In PWM mode an all-zero pattern never starts a sequence. On entry to PWM mode the last-sent pattern counts as all-zero.
- R11: Data writes are dropped while PWM mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| pwm_lvl | input | 17 | Channel levels from the PWM generators |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_data | output | 1 | Serial data to the chain |
| sr_latch | output | 1 | Latch strobe to the chain |

## Verification
The assertions check several rules on every cycle:
- The three chain pins stay quiet whenever busy is low.
- The shift clock and the latch are never high together.
- Busy rises only after an accepted start.
- The stored data word cannot change while busy.
- A blocked switch into PWM mode leaves the mode off.
- An all-zero pattern in PWM mode never raises busy.

Only the bench scenarios can show the rest: the bit order and content of each shifted frame, the slot length for each divider code, the measured clock-to-data delay including the limit on it, the latch width, the sequence without a latch, and the suppression of repeated PWM patterns over many cycles.

// File: rtl/sled_pkg.sv
package sled_pkg;

   // word addresses of the register block
   localparam int unsigned REG_DATA = 0;
   localparam int unsigned REG_DIV  = 1;
   localparam int unsigned REG_DLY  = 2;
   localparam int unsigned REG_MODE = 3;

   // mode register bit positions
   localparam int unsigned MODE_NOLATCH = 0;
   localparam int unsigned MODE_PWM     = 1;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SHIFT = 2'd1,
      SQ_LATCH = 2'd2
   } sq_state_t;

endpackage

// File: rtl/sled_regs.sv
module sled_regs #(
   parameter int NBITS    = 17,
   parameter int DW       = 32,
   parameter int ADDR_W   = 2,
   parameter int DIV_W    = 2,
   parameter int DLY_W    = 4,
   parameter int BUSY_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic              busy,
   output logic [DW-1:0]     rdata,
   output logic [NBITS-1:0]  data_q,
   output logic [DIV_W-1:0]  div_q,
   output logic [DLY_W-1:0]  dly_q,
   output logic              alt_q,
   output logic              pwm_q,
   output logic              sw_start
);
   import sled_pkg::*;

   logic hit_data, hit_div, hit_dly, hit_mode;
   logic pwm_req;
   logic unused_wbits;

   assign hit_data = we && (addr == ADDR_W'(REG_DATA));
   assign hit_div  = we && (addr == ADDR_W'(REG_DIV));
   assign hit_dly  = we && (addr == ADDR_W'(REG_DLY));
   assign hit_mode = we && (addr == ADDR_W'(REG_MODE));

   assign unused_wbits = ^wdata[DW-1:NBITS];

   // data is taken only when the chain is free and software owns it
   assign sw_start = hit_data && !busy && !pwm_q;

   // entering PWM mode is refused while a sequence runs; leaving is always allowed
   assign pwm_req = wdata[MODE_PWM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         div_q  <= '0;
         dly_q  <= '0;
         alt_q  <= 1'b0;
         pwm_q  <= 1'b0;
      end else begin
         if (sw_start) data_q <= wdata[NBITS-1:0];
         if (hit_div)  div_q  <= wdata[DIV_W-1:0];
         if (hit_dly)  dly_q  <= wdata[DLY_W-1:0];
         if (hit_mode) begin
            alt_q <= wdata[MODE_NOLATCH];
            if (!pwm_req)
               pwm_q <= 1'b0;
            else if (pwm_q || !busy)
               pwm_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (int'(addr))
         REG_DATA: begin
            rdata[NBITS-1:0] = data_q;
            rdata[BUSY_BIT]  = busy;
         end
         REG_DIV:  rdata[DIV_W-1:0] = div_q;
         REG_DLY:  rdata[DLY_W-1:0] = dly_q;
         REG_MODE: begin
            rdata[MODE_NOLATCH] = alt_q;
            rdata[MODE_PWM]     = pwm_q;
         end
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/sled_timer.sv
module sled_timer #(
   parameter int DIV_W = 2,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] code,
   input  logic [DLY_W-1:0] dly_in,
   output logic             slot_end,
   output logic             clk_win
);
   localparam int NCODE = 2 ** DIV_W;
   localparam int LEN_W = NCODE + 2;
   localparam int CW    = ((LEN_W > DLY_W) ? LEN_W : DLY_W) + 1;

   logic [LEN_W-1:0] len_tab [NCODE];
   logic [LEN_W-1:0] len_q, cnt_q;
   logic [CW-1:0]    dly_q, half_m1, dly_ext, cnt_ext;

   // slot length per divider code: 4, 8, 16, ...
   for (genvar g = 0; g < NCODE; g++) begin : g_len
      assign len_tab[g] = LEN_W'(4) << g;
   end

   assign half_m1 = CW'(len_tab[code] >> 1) - CW'(1);
   assign dly_ext = CW'(dly_in);
   assign cnt_ext = CW'(cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= LEN_W'(4);
         dly_q <= '0;
         cnt_q <= '0;
      end else if (restart) begin
         // timing is frozen for the whole sequence
         len_q <= len_tab[code];
         dly_q <= (dly_ext > half_m1) ? half_m1 : dly_ext;
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= slot_end ? '0 : cnt_q + LEN_W'(1);
      end else begin
         cnt_q <= '0;
      end
   end

   assign slot_end = run && (cnt_q == len_q - LEN_W'(1));
   assign clk_win  = run && (cnt_ext > dly_q) &&
                     (cnt_ext <= dly_q + CW'(len_q >> 1));

endmodule

// File: rtl/sled_seq.sv
module sled_seq #(
   parameter int NBITS       = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_start,
   input  logic [NBITS-1:0] sw_data,
   input  logic             pwm_on,
   input  logic             alt_mode,
   input  logic [NBITS-1:0] pwm_lvl,
   input  logic             slot_end,
   input  logic             clk_win,
   output logic             busy,
   output logic             start,
   output logic [NBITS-1:0] pat_o,
   output logic             sclk,
   output logic             sdata,
   output logic             latch
);
   import sled_pkg::*;

   localparam int IDX_W = $clog2(NBITS);

   sq_state_t        st_q;
   logic [IDX_W-1:0] idx_q;
   logic [NBITS-1:0] sh_q, last_q, pat;
   logic             alt_run_q, pwm_start;

   // channel levels sampled through an optional register chain
   if (SYNC_STAGES == 0) begin : g_nosync
      assign pat = pwm_lvl;
   end else begin : g_sync
      logic [NBITS-1:0] stg_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[0] <= '0;
         else        stg_q[0] <= pwm_lvl;
      end
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
      assign pat = stg_q[SYNC_STAGES-1];
   end

   assign pat_o     = pat;
   assign busy      = (st_q != SQ_IDLE);
   assign pwm_start = pwm_on && !busy && (pat != '0) && (pat != last_q);
   assign start     = sw_start || pwm_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
      end else if (!pwm_on) begin
         last_q <= '0;
      end else if (pwm_start) begin
         last_q <= pat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         idx_q     <= '0;
         sh_q      <= '0;
         alt_run_q <= 1'b0;
      end else begin
         unique case (st_q)
            SQ_IDLE: begin
               if (start) begin
                  st_q      <= SQ_SHIFT;
                  idx_q     <= IDX_W'(NBITS - 1);
                  sh_q      <= sw_start ? sw_data : pat;
                  alt_run_q <= alt_mode;
               end
            end
            SQ_SHIFT: begin
               if (slot_end) begin
                  if (idx_q == '0) begin
                     st_q <= alt_run_q ? SQ_IDLE : SQ_LATCH;
                  end else begin
                     idx_q <= idx_q - IDX_W'(1);
                  end
                  sh_q <= {sh_q[NBITS-2:0], 1'b0};
               end
            end
            SQ_LATCH: begin
               if (slot_end) st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign sclk  = (st_q == SQ_SHIFT) && clk_win;
   assign sdata = (st_q == SQ_SHIFT) && sh_q[NBITS-1];
   assign latch = (st_q == SQ_LATCH);

endmodule

// File: rtl/serial_led_out.sv
module serial_led_out #(
   parameter int NBITS       = 17,
   parameter int DW          = 32,
   parameter int ADDR_W      = 2,
   parameter int DIV_W       = 2,
   parameter int DLY_W       = 4,
   parameter int BUSY_BIT    = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NBITS-1:0]  pwm_lvl,
   output logic              sr_clk,
   output logic              sr_data,
   output logic              sr_latch
);
   // elaboration checks on the parameter set
   if (NBITS < 2 || NBITS >= BUSY_BIT) begin : g_bad_nbits
      $error("NBITS must be at least 2 and below BUSY_BIT");
   end
   if (BUSY_BIT >= DW) begin : g_bad_busy
      $error("BUSY_BIT must fit in the data width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must reach four registers");
   end
   if (DIV_W < 1 || DIV_W > 3 || DLY_W < 1 || DLY_W > NBITS) begin : g_bad_fields
      $error("divider or delay field width out of range");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic [NBITS-1:0] data_w, pat_w;
   logic [DIV_W-1:0] div_w;
   logic [DLY_W-1:0] dly_w;
   logic             alt_w, pwm_w, sw_start_w, start_w, busy_w;
   logic             slot_end_w, clk_win_w;

   sled_regs #(
      .NBITS(NBITS), .DW(DW), .ADDR_W(ADDR_W),
      .DIV_W(DIV_W), .DLY_W(DLY_W), .BUSY_BIT(BUSY_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .busy(busy_w), .rdata(bus_rdata),
      .data_q(data_w), .div_q(div_w), .dly_q(dly_w),
      .alt_q(alt_w), .pwm_q(pwm_w), .sw_start(sw_start_w)
   );

   sled_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .restart(start_w), .run(busy_w),
      .code(div_w), .dly_in(dly_w),
      .slot_end(slot_end_w), .clk_win(clk_win_w)
   );

   sled_seq #(.NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .sw_start(sw_start_w), .sw_data(bus_wdata[NBITS-1:0]),
      .pwm_on(pwm_w), .alt_mode(alt_w), .pwm_lvl(pwm_lvl),
      .slot_end(slot_end_w), .clk_win(clk_win_w),
      .busy(busy_w), .start(start_w), .pat_o(pat_w),
      .sclk(sr_clk), .sdata(sr_data), .latch(sr_latch)
   );

endmodule

// File: rtl/sled_chk.sv
module sled_chk #(
   parameter int NBITS = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             start,
   input logic             pwm_on,
   input logic [NBITS-1:0] pat,
   input logic [NBITS-1:0] data,
   input logic             sclk,
   input logic             sdata,
   input logic             latch
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sdata && !latch));                         // R1
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);                                                // R2
   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));                                  // R2
   AST_CLK_NOT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !latch);                                               // R3
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data));                                        // R6
   AST_PWM_ENTRY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pwm_on) |=> !pwm_on);                                 // R8
   AST_ZERO_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && !busy && pat == '0) |=> !busy);                      // R10
endmodule

bind serial_led_out sled_chk #(.NBITS(NBITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .start(start_w),
   .pwm_on(pwm_w), .pat(pat_w), .data(data_w),
   .sclk(sr_clk), .sdata(sr_data), .latch(sr_latch)
);

// File: tb/serial_led_out_bench.sv
`timescale 1ns/1ps
module serial_led_out_bench;
   localparam int NB = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NB-1:0] pwm_lvl = '0;
   logic        sr_clk, sr_data, sr_latch;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   serial_led_out u_serial_led_out (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_lvl(pwm_lvl),
      .sr_clk(sr_clk), .sr_data(sr_data), .sr_latch(sr_latch)
   );

   // {data17, div2, dly4, expected rise offset 6, expected busy length 10}
   localparam logic [38:0] VEC [6] = '{
      {17'h1A5A5, 2'd0, 4'd0,  6'd1,  10'd72},
      {17'h00001, 2'd1, 4'd2,  6'd3,  10'd144},
      {17'h10000, 2'd2, 4'd7,  6'd8,  10'd288},
      {17'h1FFFF, 2'd3, 4'd15, 6'd16, 10'd576},
      {17'h0AAAA, 2'd0, 4'd5,  6'd2,  10'd72},
      {17'h00000, 2'd0, 4'd0,  6'd1,  10'd72}
   };

   // ---------------- pin monitor (samples at falling edge) ----------------
   int cyc = 0, t_busy = 0, t_rise = 0, first_off = 0, hi_w = 0;
   int t_lat = 0, lat_w = 0, bitcnt = 0, done_cnt = 0, lat_cnt = 0, blen = 0;
   bit first_seen = 1'b0;
   logic [NB-1:0] cur = '0, frame = '0;
   logic p_clk = 1'b0, p_lat = 1'b0, p_busy = 1'b0;

   always @(negedge clk) begin
      logic b;
      cyc++;
      b = bus_rdata[31] & (bus_addr == 2'd0);
      if (sr_clk && !p_clk) begin
         cur = {cur[NB-2:0], sr_data};
         bitcnt++;
         t_rise = cyc;
         if (!first_seen) begin
            first_seen = 1'b1;
            first_off  = cyc - t_busy;
         end
      end
      if (!sr_clk && p_clk) hi_w = cyc - t_rise;
      if (sr_latch && !p_lat) begin t_lat = cyc; lat_cnt++; end
      if (!sr_latch && p_lat) lat_w = cyc - t_lat;
      if (b && !p_busy) begin
         t_busy = cyc; first_seen = 1'b0; bitcnt = 0; cur = '0;
      end
      if (!b && p_busy && bus_addr == 2'd0) begin
         blen = cyc - t_busy; frame = cur; done_cnt++;
      end
      p_clk = sr_clk; p_lat = sr_latch;
      if (bus_addr == 2'd0) p_busy = b;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_addr = 2'd0;
   endtask

   task automatic wait_done(input int start_cnt, input string req);
      for (int k = 0; k < 3000; k++) begin
         @(posedge clk);
         if (done_cnt != start_cnt) return;
      end
      chk(1'b0, req, 0, 1);
   endtask

   task automatic idle_for(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 150000);
      if (!ended) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- main ----------------
   initial begin
      logic [31:0] r;
      int dc, lc;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!sr_clk && !sr_data && !sr_latch, "R1 pins low in reset", {sr_clk, sr_data, sr_latch}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), r);
         chk(r == 32'd0, "R1 register reset value", r, 0);
      end

      // table-driven sequences: R2 R3 R4 R5
      for (int i = 0; i < 6; i++) begin
         logic [38:0] v;
         logic [16:0] d;
         int n;
         v = VEC[i];
         d = v[38:22];
         n = 4 << v[21:20];
         wr(2'd1, 32'(v[21:20]));
         wr(2'd2, 32'(v[19:16]));
         dc = done_cnt;
         wr(2'd0, 32'(d));
         #1;
         chk(bus_rdata[31] == 1'b1, "R2 busy set after write", bus_rdata[31], 1);
         chk(bus_rdata[16:0] == d, "R2 data readback", bus_rdata[16:0], d);
         wait_done(dc, "R3 sequence did not end");
         chk(frame == d, "R3 shifted frame", frame, d);
         chk(bitcnt == NB, "R3 bit count", bitcnt, NB);
         chk(blen == int'(v[9:0]), "R4 busy length", blen, v[9:0]);
         chk(lat_w == n, "R3 latch width", lat_w, n);
         chk(hi_w == n / 2, "R4 clock high width", hi_w, n / 2);
         chk(first_off == int'(v[15:10]), "R5 clock delay", first_off, v[15:10]);
      end

      // R6: data write while busy is dropped
      dc = done_cnt;
      wr(2'd0, 32'h0_1234);
      wr(2'd0, 32'h0_0FFF);
      rd(2'd0, r);
      chk(r[16:0] == 17'h01234, "R6 readback after blocked write", r[16:0], 17'h01234);
      wait_done(dc, "R6 sequence did not end");
      chk(frame == 17'h01234, "R6 shifted frame unchanged", frame, 17'h01234);
      idle_for(150);
      chk(done_cnt == dc + 1, "R6 no extra sequence", done_cnt - dc, 1);

      // R7: no-latch device mode
      wr(2'd3, 32'h1);
      dc = done_cnt; lc = lat_cnt;
      wr(2'd0, 32'h1_0F0F);
      wait_done(dc, "R7 sequence did not end");
      chk(lat_cnt == lc, "R7 no latch pulse", lat_cnt - lc, 0);
      chk(blen == 68, "R7 busy length", blen, 68);
      chk(frame == 17'h10F0F, "R7 frame", frame, 17'h10F0F);
      wr(2'd3, 32'h0);

      // R8: PWM entry refused while busy
      dc = done_cnt;
      wr(2'd0, 32'h0);
      wr(2'd3, 32'h2);
      rd(2'd3, r);
      chk(r[1] == 1'b0, "R8 PWM entry blocked while busy", r[1], 0);
      wait_done(dc, "R8 clearing sequence did not end");
      wr(2'd3, 32'h2);
      rd(2'd3, r);
      chk(r[1] == 1'b1, "R8 PWM entry when idle", r[1], 1);

      // R10: zero pattern never shifts
      dc = done_cnt;
      idle_for(100);
      chk(done_cnt == dc && !sr_latch, "R10 zero pattern on entry", done_cnt - dc, 0);

      // R9: pattern change starts a sequence
      pwm_lvl = 17'h00813;
      wait_done(dc, "R9 PWM sequence did not start");
      chk(frame == 17'h00813, "R9 PWM frame", frame, 17'h00813);
      dc = done_cnt;
      idle_for(150);
      chk(done_cnt == dc, "R9 steady pattern no repeat", done_cnt - dc, 0);
      pwm_lvl = 17'h10001;
      wait_done(dc, "R9 second PWM sequence did not start");
      chk(frame == 17'h10001, "R9 changed PWM frame", frame, 17'h10001);

      // R10: going to zero does not shift
      dc = done_cnt;
      pwm_lvl = '0;
      idle_for(150);
      chk(done_cnt == dc, "R10 zero pattern after data", done_cnt - dc, 0);

      // R11: data write ignored in PWM mode
      wr(2'd0, 32'h0_5555);
      rd(2'd0, r);
      chk(r[16:0] == 17'h0 && r[31] == 1'b0, "R11 data write in PWM mode", r, 0);
      idle_for(100);
      chk(done_cnt == dc, "R11 no sequence from data write", done_cnt - dc, 0);

      // leaving PWM mode
      wr(2'd3, 32'h0);
      rd(2'd3, r);
      chk(r[1:0] == 2'b00, "R8 PWM exit", r[1:0], 0);

      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule